// File: doc/BRIEF.md
# Two-Halfword Receive Buffer Readout

This block holds the most recent 32-bit serial-bus word that a framer delivered and lets a host read it over a 16-bit data bus in two read cycles. The framer presents a complete word together with a one-cycle transfer strobe. The host then pulses an active-low read strobe twice. The first read returns the low halfword and the second returns the high halfword.

A data-ready flag rises when a word arrives and falls when the first read completes. Each new word overwrites the buffer whether or not the previous word was read. A new word also forces the half-select pointer back to the low half, so a host that had read only the first half of the old word starts again on the first half of the new word. A read completes on the rising edge of the read strobe, which is detected in the block's clock domain.

Top module: `halfword_rdbuf`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, data_ready is 0 and dout is 0. The first completed read after reset acts as a read of the low half.
- R2: In the cycle after word_load is high, data_ready is 1 and dout shows word_in[15:0] of that word. Received bit 1 sits at word_in[0] and appears on dout[0].
- R3: A read completes in the cycle after rd_n goes from 0 to 1. When a read completes with the pointer on the low half and no word is loaded, data_ready goes to 0 and dout then shows bits [31:16] of the stored word.
- R4: When a read completes with the pointer on the high half and no word is loaded, dout returns to bits [15:0] of the stored word and data_ready keeps its value.
- R5: A loaded word always replaces the stored word, even if data_ready was still 1.
- R6: A load made after only the first half has been read puts dout back on the low half of the new word.
- R7: When a load and a read completion fall in the same clock, the load wins: the pointer goes to the low half, data_ready is 1, and dout shows the new word's bits [15:0].
- R8: If rd_n is held low or held high and no word is loaded, dout and data_ready do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | 32 | Received word from the framer; received bit 1 is at index 0 |
| word_load | input | 1 | One-cycle transfer strobe for word_in |
| rd_n | input | 1 | Active-low host read strobe |
| dout | output | 16 | Selected halfword |
| data_ready | output | 1 | A new word is waiting for its first read |

## Verification
The bench applies clean two-read sequences for several distinct words. This shows that the halves come out in the right order and that the flag clears on the first read and not on the second. Words loaded back to back with no read, and words loaded between the first and second reads, separate true overwrite from queuing. They also show whether the pointer is reset on each load. A load that coincides with the end of a read, and a read strobe held low across many cycles, show whether the load takes priority and whether a read is counted on the rising edge only.

// File: rtl/halfword_rdbuf.sv
`timescale 1ns/1ps
module halfword_rdbuf #(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_load,
  input  logic              rd_n,
  output logic [BUS_W-1:0]  dout,
  output logic              data_ready
);
  localparam int HI_LSB = WORD_W - BUS_W;

  logic [WORD_W-1:0] held;
  logic              upper;
  logic              rd_q;
  logic              rd_done;

  assign rd_done = rd_n & ~rd_q;
  assign dout    = upper ? held[WORD_W-1:HI_LSB] : held[BUS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= '0;
      upper      <= 1'b0;
      rd_q       <= 1'b1;
      data_ready <= 1'b0;
    end else begin
      rd_q <= rd_n;
      if (word_load) begin
        held       <= word_in;
        upper      <= 1'b0;
        data_ready <= 1'b1;
      end else if (rd_done) begin
        upper <= ~upper;
        if (!upper) data_ready <= 1'b0;
      end
    end
  end

  assert_load_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |=> data_ready && dout == $past(word_in[BUS_W-1:0]));

  assert_first_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !word_load && !upper) |=> !data_ready && dout == held[WORD_W-1:HI_LSB]);

  assert_second_read_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !word_load && upper) |=> $stable(data_ready) && dout == held[BUS_W-1:0]);

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && rd_done) |=> !upper && data_ready);

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_load && !rd_done) |=> $stable(dout) && $stable(data_ready));
endmodule

// File: tb/tb_halfword_rdbuf.sv
`timescale 1ns/1ps
module tb_halfword_rdbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_in = '0;
  logic        word_load = 1'b0;
  logic        rd_n = 1'b1;
  logic [15:0] dout;
  logic        data_ready;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string tag = "R1";

  logic [31:0] m_word;
  bit          m_hi, m_rdy, m_rdprev;

  always #2 clk = ~clk;

  halfword_rdbuf dut (.clk(clk), .rst_n(rst_n), .word_in(word_in),
    .word_load(word_load), .rd_n(rd_n), .dout(dout), .data_ready(data_ready));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 0; m_hi = 0; m_rdy = 0; m_rdprev = 1;
    end else begin
      if (word_load) begin
        m_word = word_in; m_hi = 0; m_rdy = 1;
      end else if (rd_n && !m_rdprev) begin
        if (!m_hi) m_rdy = 0;
        m_hi = !m_hi;
      end
      m_rdprev = rd_n;
    end
  end

  always @(negedge clk) begin
    logic [15:0] exp_d;
    exp_d = m_hi ? m_word[31:16] : m_word[15:0];
    vectors++;
    if (dout !== exp_d || data_ready !== m_rdy) begin
      miscompares++;
      $display("FAIL %s: dout=%h rdy=%b expected dout=%h rdy=%b", tag, dout, data_ready, exp_d, m_rdy);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic load(logic [31:0] w);
    word_in = w; word_load = 1; tick(); word_load = 0;
  endtask

  task automatic rd(int low = 1);
    rd_n = 0; tick(low); rd_n = 1; tick();
  endtask

  initial begin
    tick(3);
    rst_n = 1; tick(2);
    tag = "R2"; load(32'hA5A5_1234); tick(2);
    tag = "R3"; rd(); tick(2);
    tag = "R4"; rd(); tick(2);
    tag = "R2"; load(32'h8000_0001); tick();
    tag = "R3"; rd(3);
    tag = "R4"; rd(2); tick();
    tag = "R5"; load(32'h1111_2222); load(32'h3333_4444); tick(2); rd(); rd();
    tag = "R6"; load(32'hDEAD_BEEF); rd(); load(32'hCAFE_F00D); tick(); rd(); rd();
    tag = "R7"; load(32'h0F0F_F0F0); rd_n = 0; tick(2);
    word_in = 32'h7654_3210; rd_n = 1; word_load = 1; tick(); word_load = 0; tick(2);
    rd(); rd();
    tag = "R8"; load(32'hFFFF_0000); rd_n = 0; tick(20); rd_n = 1; tick(20);
    tag = "R1"; rst_n = 0; tick(2); rst_n = 1; tick(); rd(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule